// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Unit

This block holds the 8-bit status register of a serial NOR flash and decides whether writes to the array may proceed. The command decoder passes it one-cycle events: an opcode strobe, a data-byte strobe and the chip-select release. The block keeps the write-enable latch and the four protect bits with their lock bit. It turns the protect code into a protected window at the top of the address space. For each request address it reports whether a program or erase may go ahead, and it reports separately whether a full-array erase is permitted.

Status writes take effect only at the chip-select release that ends the frame. They need an armed write-enable latch, or an unlock opcode sent as the command just before. The lock bit, together with a low level on the write-protect pin, freezes the protection fields. The busy flag and the auto-increment flag come from the array engine and are only mirrored into the status byte.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset the status byte is 8'h1C: the three low protect bits are 1, and the top protect bit, the lock bit, the write-enable latch, busy and auto-increment are all 0.
- R2: Status bit 0 equals `engine_busy` and bit 6 equals `aai_mode` in the same cycle. Bits 5..2 hold protect bits 3..0, bit 7 holds the lock bit and bit 1 holds the write-enable latch.
- R3: Opcode 8'h06 sets the write-enable latch. Opcode 8'h04 and an `op_done` pulse clear it.
- R4: A status write (opcode 8'h01) is authorised if the latch is set when the opcode arrives, or if the previous opcode was 8'h50. Any other opcode that follows 8'h50 cancels that unlock.
- R5: An authorised status write commits on `cs_rise`. It loads data bits 7 and 5..2 and ignores bits 6, 1 and 0. A frame with no data byte changes nothing, and the `cs_rise` that ends any status-write frame clears the latch.
- R6: While `wp_n` is low and the lock bit is 1, status writes are refused. While `wp_n` is high the lock bit has no effect. With `wp_n` low, one write may set the lock bit and change the protect bits together.
- R7: With protect bit 3 ignored, code 0 in bits 2..0 protects nothing. Codes 1, 2, 3 and 4 protect the top 1/16, 1/8, 1/4 and 1/2 of the address space. Codes 5, 6 and 7 protect all of it.
- R8: `write_ok` is high exactly when the latch is set and `req_addr` lies outside the protected window.
- R9: `chip_erase_ok` is high exactly when the latch is set and all four protect bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Opcode strobe, one cycle |
| cmd_code | input | 8 | Decoded opcode |
| data_valid | input | 1 | Data-byte strobe, one cycle |
| data_byte | input | 8 | Data byte following an opcode |
| cs_rise | input | 1 | Chip-select release event, one cycle |
| wp_n | input | 1 | Write-protect pin level, active low |
| req_addr | input | ADDR_W | Address of the pending program or erase |
| engine_busy | input | 1 | Array engine busy flag |
| aai_mode | input | 1 | Array engine auto-increment mode flag |
| op_done | input | 1 | Program or erase finished, one cycle |
| status_byte | output | 8 | Status register value |
| write_ok | output | 1 | Program or erase at `req_addr` is allowed |
| chip_erase_ok | output | 1 | Full-array erase is allowed |

## Verification
The bench sweeps every protect code against every address of a 256-byte configuration. An off-by-one window boundary, or a wrong size for codes 5 to 7, would show up as a wrong `write_ok` on the edge addresses. It also sends an unrelated opcode between the unlock and the status write. A design that kept the unlock armed would then accept a write that must be refused. With the pin low and the lock set, the bench tries to clear the lock, and a design that let the lock bit clear itself would lose protection. Finally it checks that only the top protect bit set still blocks a full-array erase, which catches a design that looked at the low three bits alone.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_EWSR = 8'h50;

  // status byte layout, MSB first
  typedef struct packed {
    logic       lock;
    logic       aai;
    logic [3:0] bp;
    logic       wel;
    logic       busy;
  } stat_t;

  localparam logic [3:0] BP_RESET = 4'b0111;
endpackage

// File: rtl/fsr_wel.sv
module fsr_wel
  import flash_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       op_done,
  input  logic       swr_end,
  output logic       wel
);
  logic wel_q;
  logic set_ev, clr_ev;

  assign set_ev = cmd_valid && (cmd_code == OP_WREN);
  assign clr_ev = op_done || swr_end || (cmd_valid && (cmd_code == OP_WRDI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (clr_ev) wel_q <= 1'b0;
    else if (set_ev) wel_q <= 1'b1;
  end

  assign wel = wel_q;

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_WREN && !op_done && !swr_end) |=> wel_q); // R3
  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !wel_q); // R3
endmodule

// File: rtl/fsr_lock_regs.sv
module fsr_lock_regs
  import flash_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       data_valid,
  input  logic [7:0] data_byte,
  input  logic       cs_rise,
  input  logic       wp_n,
  input  logic       wel,
  output logic [3:0] bp,
  output logic       lock,
  output logic       swr_end
);
  logic [3:0] bp_q;
  logic       lock_q;
  logic       unlock_q;   // previous opcode was the unlock
  logic       frame_q;    // status-write frame open
  logic       auth_q;     // frame was authorised at opcode time
  logic       have_q;     // data byte captured
  logic [7:0] data_q;
  logic       wrsr_ev, commit;

  assign wrsr_ev = cmd_valid && (cmd_code == OP_WRSR);
  assign swr_end = cs_rise && frame_q;
  assign commit  = swr_end && have_q && auth_q && (wp_n || !lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      frame_q  <= 1'b0;
      auth_q   <= 1'b0;
      have_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      if (cmd_valid) begin
        unlock_q <= (cmd_code == OP_EWSR);
        frame_q  <= wrsr_ev;
        auth_q   <= wrsr_ev && (wel || unlock_q);
        have_q   <= 1'b0;
      end else if (data_valid && frame_q && !have_q) begin
        data_q <= data_byte;
        have_q <= 1'b1;
      end
      if (cs_rise) frame_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= BP_RESET;
      lock_q <= 1'b0;
    end else if (commit) begin
      bp_q   <= data_q[5:2];
      lock_q <= data_q[7];
    end
  end

  assign bp   = bp_q;
  assign lock = lock_q;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && lock_q) |=> ($stable(bp_q) && lock_q)); // R6
  AST_NO_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame_q && !auth_q) |=> $stable({lock_q, bp_q})); // R4
  AST_ONE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != OP_EWSR) |=> !unlock_q); // R4
endmodule

// File: rtl/fsr_range_decode.sv
module fsr_range_decode #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        code,
  output logic              hit
);
  localparam int TOP_BITS = 4;

  // top 1/2^(5-code) of the space for codes 1..4
  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic [2:0] c);
    logic h;
    h = 1'b1;
    if (c == 3'd0) return 1'b0;
    if (c >= 3'd5) return 1'b1;
    for (int i = 0; i < TOP_BITS; i++)
      if (i < 5 - int'(c)) h = h & a[ADDR_W-1-i];
    return h;
  endfunction

  generate
    if (ADDR_W < TOP_BITS) begin : g_bad
      initial $error("ADDR_W too small");
    end
  endgenerate

  assign hit = in_window(addr, code);
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              data_valid,
  input  logic [7:0]        data_byte,
  input  logic              cs_rise,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              engine_busy,
  input  logic              aai_mode,
  input  logic              op_done,
  output logic [7:0]        status_byte,
  output logic              write_ok,
  output logic              chip_erase_ok
);
  logic       wel, lock, swr_end, prot_hit;
  logic [3:0] bp;
  stat_t      st;

  fsr_wel u_wel (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .op_done(op_done), .swr_end(swr_end), .wel(wel)
  );

  fsr_lock_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .data_valid(data_valid), .data_byte(data_byte), .cs_rise(cs_rise),
    .wp_n(wp_n), .wel(wel), .bp(bp), .lock(lock), .swr_end(swr_end)
  );

  fsr_range_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .code(bp[2:0]), .hit(prot_hit)
  );

  always_comb begin
    st.lock = lock;
    st.aai  = aai_mode;
    st.bp   = bp;
    st.wel  = wel;
    st.busy = engine_busy;
  end

  assign status_byte   = st;
  assign write_ok      = wel && !prot_hit;
  assign chip_erase_ok = wel && (bp == 4'd0);

  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[4:2] >= 3'd5) |-> !write_ok); // R7
  AST_CHIP_BP: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_ok |-> (status_byte[5:2] == 4'd0 && status_byte[1])); // R9
endmodule

// File: tb/test_flash_status_ctl.sv
module test_flash_status_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_code = '0;
  logic          data_valid = 1'b0;
  logic [7:0]    data_byte = '0;
  logic          cs_rise = 1'b0;
  logic          wp_n = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic          engine_busy = 1'b0;
  logic          aai_mode = 1'b0;
  logic          op_done = 1'b0;
  logic [7:0]    status_byte;
  logic          write_ok, chip_erase_ok;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_ctl #(.ADDR_W(AW)) i_flash_status_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .data_valid(data_valid), .data_byte(data_byte), .cs_rise(cs_rise),
    .wp_n(wp_n), .req_addr(req_addr), .engine_busy(engine_busy),
    .aai_mode(aai_mode), .op_done(op_done), .status_byte(status_byte),
    .write_ok(write_ok), .chip_erase_ok(chip_erase_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask
  task automatic dat(input logic [7:0] d);
    @(negedge clk); data_valid = 1'b1; data_byte = d;
    @(negedge clk); data_valid = 1'b0;
  endtask
  task automatic frame_end();
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
  endtask
  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask
  task automatic wren(); op(8'h06); frame_end(); endtask
  task automatic swrite(input logic [7:0] d); op(8'h01); dat(d); frame_end(); endtask

  // expected window: lowest protected address, 2^AW meaning none
  function automatic int low_bound(input int code);
    int span;
    span = 1 << AW;
    if (code == 0) return span;
    if (code >= 5) return 0;
    return span - (span >> (5 - code));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_byte, 8'h1C);
    chk("R1 write_ok", write_ok, 0);
    chk("R1 chip_ok", chip_erase_ok, 0);

    // R2 mirrored bits
    engine_busy = 1'b1; aai_mode = 1'b1; #1;
    chk("R2 busy+aai", status_byte, 8'h5D);
    engine_busy = 1'b0; aai_mode = 1'b0; #1;
    chk("R2 cleared", status_byte, 8'h1C);

    // R3 latch
    wren();       chk("R3 set", status_byte, 8'h1E);
    op(8'h04);    chk("R3 wrdi", status_byte, 8'h1C);
    wren(); done_pulse(); chk("R3 op_done", status_byte, 8'h1C);

    // R4 authorisation
    swrite(8'h00);                         chk("R4 no auth", status_byte, 8'h1C);
    op(8'h50); frame_end(); swrite(8'h08); chk("R4 unlock", status_byte, 8'h08);
    op(8'h50); frame_end(); op(8'h05); frame_end(); swrite(8'h00);
    chk("R4 cancelled", status_byte, 8'h08);

    // R5 commit rules
    wren(); op(8'h01); frame_end();        chk("R5 no data", status_byte, 8'h08);
    wren(); op(8'h01); dat(8'h10);         chk("R5 before cs", status_byte, 8'h0A);
    frame_end();                           chk("R5 at cs", status_byte, 8'h10);
    wren(); swrite(8'hFF);                 chk("R5 ro bits", status_byte, 8'hBC);
    wren(); swrite(8'h00);                 chk("R5 wp high unlocks", status_byte, 8'h00);

    // R6 pin and lock
    wp_n = 1'b0;
    wren(); swrite(8'h84);                 chk("R6 set lock+bp", status_byte, 8'h84);
    wren(); swrite(8'h00);                 chk("R6 refused", status_byte, 8'h84);
    op(8'h50); frame_end(); swrite(8'h00); chk("R6 refused unlock", status_byte, 8'h84);
    wp_n = 1'b1;
    wren(); swrite(8'h00);                 chk("R6 pin high", status_byte, 8'h00);

    // R7/R8 sweep of codes and addresses, top protect bit set or clear
    for (int hb = 0; hb < 2; hb++) begin
      for (int code = 0; code < 8; code++) begin
        wren(); swrite(8'((hb << 5) | (code << 2)));
        req_addr = '0; #1;
        chk("R8 latch clear", write_ok, 0);
        wren();
        chk("R7 code", int'(status_byte[5:2]), (hb << 3) | code);
        for (int a = 0; a < (1 << AW); a++) begin
          req_addr = AW'(a); #1;
          chk("R7/R8 window", write_ok, (a < low_bound(code)) ? 1 : 0);
        end
        chk("R9 chip", chip_erase_ok, (code == 0 && hb == 0) ? 1 : 0);
        op(8'h04);
        chk("R9 no latch", chip_erase_ok, 0);
      end
    end

    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule